// File: doc/BRIEF.md
# Partitioned Packet FIFO RAM Controller

This block manages one single-port RAM of 32-bit words that is shared by all packet traffic. Software gives the receive region and each of four transmit queues a depth in words. Each transmit queue serves one IN endpoint. On an apply strobe the block checks these depths against the sizing rules. If they pass, it places the regions back to back, starting from word 0: the receive region first, then transmit queues 0 to 3.

The block keeps a write pointer, a read pointer and a fill count for each transmit queue. The application pushes words in and the serial engine pops them out. Both sides share the one RAM port through an arbiter that grants at most one access per cycle. When both sides request in the same cycle, the winner alternates. Any queue can be flushed by itself. An illegal configuration raises a sticky error, and while it is set every access is refused.

Top module: `pkt_ram_ctrl`

## Requirements
- R1: After reset no configuration is live. `cfg_ready` and `config_error` are 0, every `tx_free` is 0 and every push is refused (`app_refuse`=1, `app_gnt`=0).
- R2: On `cfg_apply`, a receive depth or queue-0 depth outside 16..256 words sets `config_error`.
- R3: Queues 1..3 need at least 16 words. A depth of 0 is accepted only when every higher-indexed queue is also 0. A zero below a non-zero queue sets `config_error`.
- R4: On `cfg_apply`, a total of all five depths above 320 words sets `config_error`.
- R5: `config_error` stays set until reset. While it is set, later applies change nothing and every push and pop is refused.
- R6: Queue i's base, on `tx_base[9*i +: 9]`, is the receive depth plus the depths of queues 0..i-1. Bases and depths change only on a legal `cfg_apply`. Depth writes without an apply leave them unchanged.
- R7: Words pop out of each queue in push order, including after the pointers wrap past the queue's last word.
- R8: `tx_free[9*i +: 9]` gives queue i's depth minus its fill. A push to a full queue is refused and sets `tx_ovf[i]` from the next cycle on. The flag stays set until that queue is flushed or a new configuration is applied.
- R9: `flush[i]` empties queue i and clears `tx_ovf[i]` by the next cycle. The other queues keep their contents and flags.
- R10: A lone eligible request is granted in the same cycle. When an eligible push and an eligible pop collide, the first collision after reset goes to the application and the winner alternates on each later collision. `app_gnt` and `eng_gnt` are never high together.
- R11: The popped word appears on `eng_rdata` with `eng_rvalid`=1 one cycle after `eng_gnt`. A pop from an empty queue is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one staged region depth |
| cfg_sel | input | 3 | Region index: 0 receive, 1..4 transmit queues 0..3 |
| cfg_depth | input | 9 | Depth in 32-bit words |
| cfg_apply | input | 1 | Check the staged depths and make them live; also empties every queue |
| cfg_ready | output | 1 | A legal configuration is live |
| config_error | output | 1 | Sticky sizing-rule violation |
| tx_base | output | 36 | Base word address of each transmit queue, 9 bits each |
| app_req | input | 1 | Application push request |
| app_sel | input | 2 | Target queue of the push |
| app_data | input | 32 | Word to push |
| app_gnt | output | 1 | Push performed at this clock edge |
| app_refuse | output | 1 | Push cannot be accepted this cycle |
| eng_req | input | 1 | Engine pop request |
| eng_sel | input | 2 | Source queue of the pop |
| eng_gnt | output | 1 | Pop performed at this clock edge |
| eng_rvalid | output | 1 | `eng_rdata` holds the popped word |
| eng_rdata | output | 32 | Popped word |
| flush | input | 4 | Per-queue flush |
| tx_free | output | 36 | Free words per queue, 9 bits each |
| tx_ovf | output | 4 | Per-queue sticky overflow flag |

## Verification
The bench aims at the sizing rules one at a time. It applies an undersized receive region, an oversized queue 0, a zero-depth queue below a used one, and a total just over 320. A checker that lets any of these through would set `cfg_ready` instead of `config_error`. The bench also applies a trailing zero-depth queue, which a checker that is too strict would reject.

A queue is filled exactly to its depth, pushed once more, partly drained and refilled, so that its pointers wrap. Wrong wrap logic would reorder or corrupt the popped words, and a missing full check would overwrite the neighbouring region and leave `tx_ovf` low. Flushing one queue while another holds an overflow shows whether the flush leaks across queues. A held collision between a push and a pop shows whether the grants alternate or one side starves.

// File: rtl/pkt_ram_pkg.sv
package pkt_ram_pkg;
  localparam int unsigned WORD_W_D    = 32;
  localparam int unsigned RAM_WORDS_D = 320;
  localparam int unsigned NUM_TX_D    = 4;
  localparam int unsigned MIN_D       = 16;
  localparam int unsigned CAP_D       = 256;

  typedef enum logic {PRI_APP = 1'b0, PRI_ENG = 1'b1} pri_e;
endpackage

// File: rtl/prc_spram.sv
module prc_spram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 320,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/prc_cfg_check.sv
module prc_cfg_check #(
  parameter int unsigned NUM_TX    = 4,
  parameter int unsigned RAM_WORDS = 320,
  parameter int unsigned MIN_DEPTH = 16,
  parameter int unsigned CAP_DEPTH = 256,
  localparam int unsigned AW     = $clog2(RAM_WORDS),
  localparam int unsigned DW     = $clog2(RAM_WORDS + 1),
  localparam int unsigned RSEL_W = $clog2(NUM_TX + 1),
  localparam int unsigned SUM_W  = DW + $clog2(NUM_TX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [RSEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]     cfg_depth,
  input  logic              cfg_apply,
  output logic              cfg_ready,
  output logic              config_error,
  output logic [DW-1:0]     live_depth [NUM_TX],
  output logic [AW-1:0]     live_base  [NUM_TX]
);
  localparam logic [DW-1:0]    MIN_W = DW'(MIN_DEPTH);
  localparam logic [DW-1:0]    CAP_W = DW'(CAP_DEPTH);
  localparam logic [SUM_W-1:0] TOT_W = SUM_W'(RAM_WORDS);

  // index 0 is the receive region, index j+1 is transmit queue j
  logic [DW-1:0]    stage  [NUM_TX+1];
  logic [SUM_W-1:0] acc    [NUM_TX+1];
  logic             bad;
  logic             tail_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NUM_TX; i++) stage[i] <= '0;
    end else if (cfg_we && (int'(cfg_sel) <= NUM_TX)) begin
      stage[cfg_sel] <= cfg_depth;
    end
  end

  always_comb begin
    bad = 1'b0;
    if (stage[0] < MIN_W || stage[0] > CAP_W) bad = 1'b1;
    if (stage[1] < MIN_W || stage[1] > CAP_W) bad = 1'b1;
    tail_zero = 1'b1;
    for (int i = NUM_TX; i >= 2; i--) begin
      if (stage[i] == '0) begin
        if (!tail_zero) bad = 1'b1;
      end else begin
        tail_zero = 1'b0;
        if (stage[i] < MIN_W) bad = 1'b1;
      end
    end
    acc[0] = SUM_W'(stage[0]);
    for (int i = 1; i <= NUM_TX; i++) acc[i] = acc[i-1] + SUM_W'(stage[i]);
    if (acc[NUM_TX] > TOT_W) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ready    <= 1'b0;
      config_error <= 1'b0;
      for (int i = 0; i < NUM_TX; i++) begin
        live_depth[i] <= '0;
        live_base[i]  <= '0;
      end
    end else if (cfg_apply && !config_error) begin
      if (bad) begin
        config_error <= 1'b1;
        cfg_ready    <= 1'b0;
      end else begin
        cfg_ready <= 1'b1;
        for (int i = 0; i < NUM_TX; i++) begin
          live_depth[i] <= stage[i+1];
          live_base[i]  <= AW'(acc[i]);
        end
      end
    end
  end
endmodule

// File: rtl/prc_txq.sv
module prc_txq #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          ovf_set,
  input  logic [DW-1:0] depth,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [DW-1:0] free,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  logic [DW-1:0] count;
  logic [AW-1:0] last;

  assign last  = AW'(depth - DW'(1));
  assign full  = (count == depth);
  assign empty = (count == '0);
  assign free  = depth - count;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) begin
        wptr  <= (wptr == last) ? '0 : wptr + AW'(1);
        count <= count + DW'(1);
      end else if (pop) begin
        rptr  <= (rptr == last) ? '0 : rptr + AW'(1);
        count <= count - DW'(1);
      end
      if (ovf_set) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/prc_arb.sv
module prc_arb
  import pkt_ram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_can,
  input  logic e_can,
  output logic a_gnt,
  output logic e_gnt
);
  pri_e pri;

  assign a_gnt = a_can && (!e_can || pri == PRI_APP);
  assign e_gnt = e_can && (!a_can || pri == PRI_ENG);

  always_ff @(posedge clk) begin
    if (rst) pri <= PRI_APP;
    else if (a_can && e_can) pri <= (pri == PRI_APP) ? PRI_ENG : PRI_APP;
  end
endmodule

// File: rtl/pkt_ram_ctrl.sv
module pkt_ram_ctrl
  import pkt_ram_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_D,
  parameter int unsigned RAM_WORDS = RAM_WORDS_D,
  parameter int unsigned NUM_TX    = NUM_TX_D,
  parameter int unsigned MIN_DEPTH = MIN_D,
  parameter int unsigned CAP_DEPTH = CAP_D,
  localparam int unsigned AW     = $clog2(RAM_WORDS),
  localparam int unsigned DW     = $clog2(RAM_WORDS + 1),
  localparam int unsigned SW     = $clog2(NUM_TX),
  localparam int unsigned RSEL_W = $clog2(NUM_TX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [RSEL_W-1:0]    cfg_sel,
  input  logic [DW-1:0]        cfg_depth,
  input  logic                 cfg_apply,
  output logic                 cfg_ready,
  output logic                 config_error,
  output logic [NUM_TX*AW-1:0] tx_base,
  input  logic                 app_req,
  input  logic [SW-1:0]        app_sel,
  input  logic [WORD_W-1:0]    app_data,
  output logic                 app_gnt,
  output logic                 app_refuse,
  input  logic                 eng_req,
  input  logic [SW-1:0]        eng_sel,
  output logic                 eng_gnt,
  output logic                 eng_rvalid,
  output logic [WORD_W-1:0]    eng_rdata,
  input  logic [NUM_TX-1:0]    flush,
  output logic [NUM_TX*DW-1:0] tx_free,
  output logic [NUM_TX-1:0]    tx_ovf
);
  logic [DW-1:0] live_depth [NUM_TX];
  logic [AW-1:0] live_base  [NUM_TX];
  logic [AW-1:0] wptr [NUM_TX];
  logic [AW-1:0] rptr [NUM_TX];
  logic [DW-1:0] free [NUM_TX];
  logic [NUM_TX-1:0] full_v, empty_v, push_v, pop_v, ovf_v;
  logic live_ok, app_open, app_can, eng_can;
  logic [AW-1:0] ram_addr;

  prc_cfg_check #(
    .NUM_TX(NUM_TX), .RAM_WORDS(RAM_WORDS),
    .MIN_DEPTH(MIN_DEPTH), .CAP_DEPTH(CAP_DEPTH)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_depth(cfg_depth), .cfg_apply(cfg_apply), .cfg_ready(cfg_ready),
    .config_error(config_error), .live_depth(live_depth), .live_base(live_base)
  );

  // a request is eligible only with a live legal config, outside an apply
  // cycle, and not aimed at a queue being flushed this cycle
  assign live_ok    = cfg_ready && !config_error && !cfg_apply;
  assign app_open   = app_req && live_ok && !flush[app_sel];
  assign app_can    = app_open && !full_v[app_sel];
  assign eng_can    = eng_req && live_ok && !flush[eng_sel] && !empty_v[eng_sel];
  assign app_refuse = app_req && !app_can;

  prc_arb u_arb (
    .clk(clk), .rst(rst), .a_can(app_can), .e_can(eng_can),
    .a_gnt(app_gnt), .e_gnt(eng_gnt)
  );

  for (genvar g = 0; g < NUM_TX; g++) begin : g_q
    assign push_v[g] = app_gnt && (app_sel == SW'(g));
    assign pop_v[g]  = eng_gnt && (eng_sel == SW'(g));
    assign ovf_v[g]  = app_open && full_v[app_sel] && (app_sel == SW'(g));

    prc_txq #(.AW(AW), .DW(DW)) u_q (
      .clk(clk), .rst(rst), .clear(flush[g] || cfg_apply),
      .push(push_v[g]), .pop(pop_v[g]), .ovf_set(ovf_v[g]),
      .depth(live_depth[g]), .wptr(wptr[g]), .rptr(rptr[g]),
      .free(free[g]), .full(full_v[g]), .empty(empty_v[g]), .ovf(tx_ovf[g])
    );

    assign tx_free[g*DW +: DW] = free[g];
    assign tx_base[g*AW +: AW] = live_base[g];
  end

  assign ram_addr = app_gnt ? (live_base[app_sel] + wptr[app_sel])
                            : (live_base[eng_sel] + rptr[eng_sel]);

  prc_spram #(.WORD_W(WORD_W), .WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(app_gnt), .re(eng_gnt), .addr(ram_addr),
    .wdata(app_data), .rdata(eng_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) eng_rvalid <= 1'b0;
    else     eng_rvalid <= eng_gnt;
  end
endmodule

// File: rtl/pkt_ram_ctrl_chk.sv
module pkt_ram_ctrl_chk #(
  parameter int unsigned NUM_TX = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              app_req,
  input logic              app_gnt,
  input logic              eng_req,
  input logic              eng_gnt,
  input logic              eng_rvalid,
  input logic              config_error,
  input logic [NUM_TX-1:0] flush,
  input logic [NUM_TX-1:0] tx_ovf
);
  p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
    !(app_gnt && eng_gnt));
  p_gnt_has_req_r10: assert property (@(posedge clk) disable iff (rst)
    (app_gnt |-> app_req) and (eng_gnt |-> eng_req));
  p_err_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    config_error |-> (!app_gnt && !eng_gnt));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    config_error |=> config_error);
  p_pop_data_r11: assert property (@(posedge clk) disable iff (rst)
    eng_gnt |=> eng_rvalid);
  p_flush_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    (flush != '0) |=> ((tx_ovf & $past(flush)) == '0));
endmodule

bind pkt_ram_ctrl pkt_ram_ctrl_chk #(.NUM_TX(NUM_TX)) u_chk (
  .clk(clk), .rst(rst), .app_req(app_req), .app_gnt(app_gnt),
  .eng_req(eng_req), .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid),
  .config_error(config_error), .flush(flush), .tx_ovf(tx_ovf)
);

// File: tb/sim_pkt_ram_ctrl.sv
`timescale 1ns/1ps
module sim_pkt_ram_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_apply, cfg_ready, config_error;
  logic [2:0]  cfg_sel;
  logic [8:0]  cfg_depth;
  logic [35:0] tx_base, tx_free;
  logic        app_req, app_gnt, app_refuse, eng_req, eng_gnt, eng_rvalid;
  logic [1:0]  app_sel, eng_sel;
  logic [31:0] app_data, eng_rdata;
  logic [3:0]  flush, tx_ovf;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expq [4][$];
  int          pend [$];

  always #5 clk = ~clk;

  pkt_ram_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_depth(cfg_depth), .cfg_apply(cfg_apply), .cfg_ready(cfg_ready),
    .config_error(config_error), .tx_base(tx_base), .app_req(app_req),
    .app_sel(app_sel), .app_data(app_data), .app_gnt(app_gnt),
    .app_refuse(app_refuse), .eng_req(eng_req), .eng_sel(eng_sel),
    .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata),
    .flush(flush), .tx_free(tx_free), .tx_ovf(tx_ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: check popped words, then log this cycle's grants
  always @(negedge clk) begin
    #2;
    if (eng_rvalid) begin
      if (pend.size() == 0) chk(0, "R11 unexpected rvalid", 1, 0);
      else begin
        int q;
        q = pend.pop_front();
        if (expq[q].size() == 0) chk(0, "R7 pop with empty model", eng_rdata, 0);
        else begin
          logic [31:0] e;
          e = expq[q].pop_front();
          chk(eng_rdata == e, "R7/R11 popped word", eng_rdata, e);
        end
      end
    end
    if (app_gnt) expq[app_sel].push_back(app_data);
    if (eng_gnt) pend.push_back(int'(eng_sel));
  end

  task automatic do_reset();
    rst = 1'b1; cfg_we = 0; cfg_apply = 0; cfg_sel = '0; cfg_depth = '0;
    app_req = 0; app_sel = '0; app_data = '0; eng_req = 0; eng_sel = '0;
    flush = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) expq[i].delete();
    pend.delete();
    @(negedge clk);
  endtask

  task automatic cfg5(input int rx, input int t0, input int t1, input int t2,
                      input int t3);
    int d [5];
    d = '{rx, t0, t1, t2, t3};
    for (int i = 0; i < 5; i++) begin
      cfg_we = 1; cfg_sel = 3'(i); cfg_depth = 9'(d[i]);
      @(negedge clk);
    end
    cfg_we = 0; cfg_apply = 1;
    @(negedge clk);
    cfg_apply = 0;
    for (int i = 0; i < 4; i++) expq[i].delete();
    #1;
  endtask

  task automatic push(input int q, input logic [31:0] d);
    @(negedge clk);
    app_req = 1; app_sel = 2'(q); app_data = d;
    #1;
    while (!app_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    app_req = 0;
  endtask

  task automatic pop(input int q);
    @(negedge clk);
    eng_req = 1; eng_sel = 2'(q);
    #1;
    while (!eng_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    eng_req = 0;
  endtask

  task automatic do_flush(input int q);
    @(negedge clk);
    flush[q] = 1'b1;
    expq[q].delete();
    @(negedge clk);
    flush = '0;
    #1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    #1;
    chk(cfg_ready == 0, "R1 cfg_ready", cfg_ready, 0);
    chk(config_error == 0, "R1 config_error", config_error, 0);
    chk(tx_free[8:0] == 0, "R1 free q0", tx_free[8:0], 0);
    @(negedge clk);
    app_req = 1; app_sel = 0; app_data = 32'h1;
    #1;
    chk(app_refuse == 1 && app_gnt == 0, "R1 push refused", {app_refuse, app_gnt}, 2'b10);
    @(negedge clk); app_req = 0;

    // R3 trailing zero queues accepted, R6 bases, R8 free
    cfg5(16, 16, 16, 0, 0);
    chk(cfg_ready == 1 && config_error == 0, "R3 trailing zero ok", {cfg_ready, config_error}, 2'b10);
    chk(tx_base[8:0] == 16, "R6 base q0", tx_base[8:0], 16);
    chk(tx_base[17:9] == 32, "R6 base q1", tx_base[17:9], 32);
    chk(tx_base[26:18] == 48 && tx_base[35:27] == 48, "R6 base q2/q3", tx_base[35:18], {9'd48, 9'd48});
    chk(tx_free[8:0] == 16, "R8 free q0 empty", tx_free[8:0], 16);
    // R6 staged write without apply changes nothing
    @(negedge clk); cfg_we = 1; cfg_sel = 1; cfg_depth = 32;
    @(negedge clk); cfg_we = 0; #1;
    chk(tx_base[17:9] == 32 && tx_free[8:0] == 16, "R6 no apply no change", {tx_base[17:9], tx_free[8:0]}, {9'd32, 9'd16});

    // R8 fill to full, then overflow
    for (int k = 0; k < 16; k++) push(0, 32'hA000 + 32'(k));
    #1;
    chk(tx_free[8:0] == 0, "R8 free q0 full", tx_free[8:0], 0);
    @(negedge clk);
    app_req = 1; app_sel = 0; app_data = 32'hDEAD;
    #1;
    chk(app_refuse == 1 && app_gnt == 0, "R8 full push refused", {app_refuse, app_gnt}, 2'b10);
    @(negedge clk); app_req = 0; #1;
    chk(tx_ovf == 4'b0001, "R8 overflow flag", tx_ovf, 4'b0001);

    // R7 wrap: pop 4, push 4, drain all 16
    for (int k = 0; k < 4; k++) pop(0);
    for (int k = 0; k < 4; k++) push(0, 32'hB000 + 32'(k));
    #1;
    chk(tx_free[8:0] == 0, "R7 refilled after wrap", tx_free[8:0], 0);
    for (int k = 0; k < 16; k++) pop(0);
    repeat (2) @(negedge clk);
    chk(expq[0].size() == 0, "R7 all words returned", expq[0].size(), 0);

    // R9 flush one queue, other untouched
    for (int k = 0; k < 3; k++) push(1, 32'hC000 + 32'(k));
    push(0, 32'hC100);
    do_flush(1);
    chk(tx_free[17:9] == 16, "R9 flushed q1 empty", tx_free[17:9], 16);
    chk(tx_free[8:0] == 15 && tx_ovf[0] == 1, "R9 q0 untouched", {tx_ovf[0], tx_free[8:0]}, {1'b1, 9'd15});
    do_flush(0);
    chk(tx_ovf[0] == 0 && tx_free[8:0] == 16, "R9 flush clears ovf", {tx_ovf[0], tx_free[8:0]}, {1'b0, 9'd16});
    // R11 pop of empty queue refused
    @(negedge clk); eng_req = 1; eng_sel = 1; #1;
    chk(eng_gnt == 0, "R11 empty pop refused", eng_gnt, 0);
    @(negedge clk); eng_req = 0;

    // R10 collisions alternate, starting with the application
    do_reset();
    cfg5(16, 16, 16, 16, 16);
    for (int k = 0; k < 3; k++) push(0, 32'hD000 + 32'(k));
    @(negedge clk);
    app_req = 1; app_sel = 1; app_data = 32'hE000;
    eng_req = 1; eng_sel = 0;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(app_gnt == ((c % 2) == 0) && eng_gnt == ((c % 2) == 1),
          "R10 alternating grant", {app_gnt, eng_gnt}, ((c % 2) == 0) ? 2'b10 : 2'b01);
      @(negedge clk);
      if (c % 2 == 0) app_data = app_data + 1;
    end
    app_req = 0; eng_req = 0;
    pop(0); pop(1); pop(1);
    repeat (2) @(negedge clk);
    chk(expq[0].size() == 0 && expq[1].size() == 0, "R10 words after collisions",
        expq[0].size() + expq[1].size(), 0);

    // R2 receive region too small
    do_reset(); cfg5(8, 16, 16, 16, 16);
    chk(config_error == 1 && cfg_ready == 0, "R2 rx below min", {config_error, cfg_ready}, 2'b10);
    // R2 queue 0 too large
    do_reset(); cfg5(16, 300, 0, 0, 0);
    chk(config_error == 1, "R2 q0 above cap", config_error, 1);
    // R3 hole below a used queue
    do_reset(); cfg5(16, 16, 0, 16, 0);
    chk(config_error == 1, "R3 zero below used", config_error, 1);
    // R4 total above 320
    do_reset(); cfg5(256, 64, 16, 0, 0);
    chk(config_error == 1, "R4 total too large", config_error, 1);
    // R5 sticky: a legal apply does not clear it and accesses stay refused
    cfg5(16, 16, 0, 0, 0);
    chk(config_error == 1 && cfg_ready == 0, "R5 error sticky", {config_error, cfg_ready}, 2'b10);
    @(negedge clk); app_req = 1; app_sel = 0; app_data = 32'h5; #1;
    chk(app_gnt == 0 && app_refuse == 1, "R5 push refused", {app_refuse, app_gnt}, 2'b10);
    @(negedge clk); app_req = 0;

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule